// File: doc/BRIEF.md
# Shrink-Expand Binary Cell Array

This block is a square grid of one-bit cells, one per pixel, that reduces bright and dark blobs toward their centres. Each cell keeps its bit in a flip-flop. The flip-flop updates only on cycles when a shared step strobe is high. A shared operation code sets the next value of every cell in the same cycle. The choices are:

- Load a pupil plane.
- Load a bright-spot plane.
- Grow, where the new value is the OR of the four orthogonal neighbours.
- Erode, where the new value is the AND of those neighbours.
- Three-of-four erode, where the new value is 1 when at least three neighbours are 1.

Two per-pixel comparator results arrive as flat bit vectors:

- **bright**: the pixel is above its bright threshold.
- **dark**: the pixel is below its pupil threshold.

The pupil plane is the OR of the two, so a glint inside the pupil leaves no hole. An external sequencer drives the step strobe and operation code in this order:

1. Load the pupil plane.
2. Grow a few steps.
3. Erode until the plane is empty.
4. Load the bright-spot plane.
5. Apply the three-of-four erode until the plane is empty.

The sequencer watches the whole array state, which is exposed as a flat vector.

Each cell uses only its four nearest neighbours, so the logic per cell does not depend on the grid size. Neighbours beyond the grid edge read as 0.

Top module: `blob_shrink_array`

## Requirements
- R1: When `rst` is high at a rising clock edge, every cell becomes 0, whatever `step` and `op` are.
- R2: With `rst` low and `step` low, no cell changes at a rising clock edge.
- R3: Op code 0 (pupil load), applied with `step`, sets each cell to `bright | dark` for its pixel.
- R4: Op code 1 (spot load), applied with `step`, sets each cell to its `bright` bit; `dark` has no effect.
- R5: Op code 2 (grow) sets each cell to the OR of its up, down, left and right neighbours. The cell's own old value is not an input.
- R6: Op code 3 (erode) sets each cell to the AND of its four orthogonal neighbours.
- R7: Op code 4 (three-of-four erode) sets a cell to 1 exactly when at least three of its four orthogonal neighbours are 1.
- R8: Neighbours outside the grid read as 0. After erode, a border cell is always 0. After three-of-four erode on a full grid, only the four corners clear.
- R9: Op codes 5, 6 and 7 with `step` high leave every cell unchanged.
- R10: Cell (row r, column c) is bit r*N+c of `cells`, `bright` and `dark`. Row r-1 is "up" and column c-1 is "left".

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Transition clock |
| rst | input | 1 | Synchronous active-high clear |
| step | input | 1 | Transition strobe; cells update only when high |
| op | input | 3 | Operation code shared by all cells |
| bright | input | N*N | Per-pixel bright-spot comparator flags |
| dark | input | N*N | Per-pixel darker-than-pupil comparator flags |
| cells | output | N*N | Array state, bit r*N+c |

## Verification
The bench goes after four corner cases:

- **Glint inside a dark region.** A design that loads only the dark flag leaves a hole in the pupil plane, and the next grow and erode results differ.
- **Single pixels in the corners, then grow.** These expose swapped up/down or left/right wiring, or a wrong row*N+c mapping, as a mirrored cross.
- **A full grid, then erode and three-of-four erode.** Edge neighbours that read 1 keep border cells alive. A three-of-four rule built from the wrong terms changes the border pattern.
- **Unused op codes, a low step strobe, and a reset applied with the strobe high.** Each must leave the grid unchanged or cleared. A decoder that falls through to a load would overwrite the state instead.

// File: rtl/blob_pkg.sv
package blob_pkg;

    localparam int OP_W = 3;

    // Operation codes shared by every cell; codes above 4 mean "hold".
    typedef enum logic [OP_W-1:0] {
        OP_LOAD_PUPIL = 3'd0,
        OP_LOAD_SPOT  = 3'd1,
        OP_GROW       = 3'd2,
        OP_ERODE      = 3'd3,
        OP_ERODE3     = 3'd4,
        OP_HOLD5      = 3'd5,
        OP_HOLD6      = 3'd6,
        OP_HOLD7      = 3'd7
    } cell_op_e;

    // Neighbour slot positions inside a cell's 4-bit neighbour word.
    localparam int NB_UP    = 0;
    localparam int NB_DOWN  = 1;
    localparam int NB_LEFT  = 2;
    localparam int NB_RIGHT = 3;
    localparam int NB_W     = 4;

endpackage

// File: rtl/flag_merge.sv
module flag_merge #(
    parameter int N = 16
) (
    input  logic [N*N-1:0] bright,
    input  logic [N*N-1:0] dark,
    output logic [N*N-1:0] pupil
);
    localparam int CELLS = N * N;

    // Pupil plane: dark pixels plus any glint sitting inside them.
    for (genvar i = 0; i < CELLS; i++) begin : g_px
        assign pupil[i] = bright[i] | dark[i];
    end

endmodule

// File: rtl/nbr_gather.sv
module nbr_gather
    import blob_pkg::*;
#(
    parameter int N = 16
) (
    input  logic [N*N-1:0]      state,
    output logic [NB_W*N*N-1:0] nbrs
);
    for (genvar r = 0; r < N; r++) begin : g_row
        for (genvar c = 0; c < N; c++) begin : g_col
            localparam int IDX = r * N + c;

            if (r > 0) begin : g_up
                assign nbrs[NB_W*IDX+NB_UP] = state[IDX-N];
            end else begin : g_up_edge
                assign nbrs[NB_W*IDX+NB_UP] = 1'b0;
            end

            if (r < N - 1) begin : g_dn
                assign nbrs[NB_W*IDX+NB_DOWN] = state[IDX+N];
            end else begin : g_dn_edge
                assign nbrs[NB_W*IDX+NB_DOWN] = 1'b0;
            end

            if (c > 0) begin : g_lf
                assign nbrs[NB_W*IDX+NB_LEFT] = state[IDX-1];
            end else begin : g_lf_edge
                assign nbrs[NB_W*IDX+NB_LEFT] = 1'b0;
            end

            if (c < N - 1) begin : g_rt
                assign nbrs[NB_W*IDX+NB_RIGHT] = state[IDX+1];
            end else begin : g_rt_edge
                assign nbrs[NB_W*IDX+NB_RIGHT] = 1'b0;
            end
        end
    end

endmodule

// File: rtl/cell_node.sv
module cell_node
    import blob_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            step,
    input  logic [OP_W-1:0] op,
    input  logic            pupil_in,
    input  logic            spot_in,
    input  logic [NB_W-1:0] nbr,
    output logic            q
);
    cell_op_e op_e;
    logic     grow_v;
    logic     erode_v;
    logic     maj_v;
    logic     nxt;

    assign op_e = cell_op_e'(op);

    always_comb begin
        grow_v  = |nbr;
        erode_v = &nbr;
        maj_v   = (nbr[NB_UP]   & nbr[NB_DOWN] & nbr[NB_LEFT])
                | (nbr[NB_UP]   & nbr[NB_DOWN] & nbr[NB_RIGHT])
                | (nbr[NB_UP]   & nbr[NB_LEFT] & nbr[NB_RIGHT])
                | (nbr[NB_DOWN] & nbr[NB_LEFT] & nbr[NB_RIGHT]);
    end

    always_comb begin
        unique case (op_e)
            OP_LOAD_PUPIL: nxt = pupil_in;
            OP_LOAD_SPOT:  nxt = spot_in;
            OP_GROW:       nxt = grow_v;
            OP_ERODE:      nxt = erode_v;
            OP_ERODE3:     nxt = maj_v;
            default:       nxt = q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= 1'b0;
        end else if (step) begin
            q <= nxt;
        end
    end

    // R1
    reset_clear_chk: assert property (@(posedge clk) rst |=> !q);

    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !step |=> $stable(q));

    // R9
    unused_op_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (step && op > 3'd4) |=> $stable(q));

    // R4
    spot_load_chk: assert property (@(posedge clk) disable iff (rst)
        (step && op == 3'd1) |=> q == $past(spot_in));

    // R6
    erode_all_chk: assert property (@(posedge clk) disable iff (rst)
        (step && op == 3'd3) |=> q == $past(&nbr));

    // R5
    grow_any_chk: assert property (@(posedge clk) disable iff (rst)
        (step && op == 3'd2) |=> q == $past(nbr != '0));

    // R7
    erode3_count_chk: assert property (@(posedge clk) disable iff (rst)
        (step && op == 3'd4) |=> q == ($past($countones(nbr)) >= 3));

endmodule

// File: rtl/blob_shrink_array.sv
module blob_shrink_array
    import blob_pkg::*;
#(
    parameter int N = 16
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            step,
    input  logic [2:0]      op,
    input  logic [N*N-1:0]  bright,
    input  logic [N*N-1:0]  dark,
    output logic [N*N-1:0]  cells
);
    localparam int CELLS = N * N;

    logic [CELLS-1:0]      pupil;
    logic [NB_W*CELLS-1:0] nbrs;

    flag_merge #(.N(N)) u_merge (
        .bright (bright),
        .dark   (dark),
        .pupil  (pupil)
    );

    nbr_gather #(.N(N)) u_nbr (
        .state (cells),
        .nbrs  (nbrs)
    );

    for (genvar i = 0; i < CELLS; i++) begin : g_cell
        cell_node u_cell (
            .clk      (clk),
            .rst      (rst),
            .step     (step),
            .op       (op),
            .pupil_in (pupil[i]),
            .spot_in  (bright[i]),
            .nbr      (nbrs[NB_W*i +: NB_W]),
            .q        (cells[i])
        );
    end

    // R3
    pupil_fill_chk: assert property (@(posedge clk) disable iff (rst)
        (step && op == 3'd0) |=> cells == $past(bright | dark));

    // R1
    array_clear_chk: assert property (@(posedge clk) rst |=> cells == '0);

    // R8 (top row cells all see a zero "up" neighbour, so erode clears them)
    border_erode_chk: assert property (@(posedge clk) disable iff (rst)
        (step && op == 3'd3) |=> cells[N-1:0] == '0);

endmodule

// File: tb/sim_blob_shrink_array.sv
module sim_blob_shrink_array;

    localparam int N  = 4;
    localparam int NC = N * N;

    typedef struct packed {
        logic        stp;
        logic [2:0]  op;
        logic [15:0] br;
        logic [15:0] dk;
        logic [15:0] ex;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 19;
    // Hex digit order: row3 row2 row1 row0; bit c of a digit is column c.
    localparam vec_t VECS [NV] = '{
        '{1'b1, 3'd0, 16'h0000, 16'h0660, 16'h0660, 8'd3},  // R3 plain dark blob
        '{1'b1, 3'd0, 16'h0020, 16'h0640, 16'h0660, 8'd3},  // R3 glint fills hole
        '{1'b1, 3'd2, 16'h0000, 16'h0000, 16'h6FF6, 8'd5},  // R5 grow
        '{1'b1, 3'd3, 16'h0000, 16'h0000, 16'h0660, 8'd6},  // R6 erode
        '{1'b1, 3'd3, 16'h0000, 16'h0000, 16'h0000, 8'd6},  // R6 erode to empty
        '{1'b1, 3'd1, 16'h0670, 16'hFFFF, 16'h0670, 8'd4},  // R4 dark ignored
        '{1'b0, 3'd0, 16'hFFFF, 16'hFFFF, 16'h0670, 8'd2},  // R2 step low
        '{1'b1, 3'd4, 16'h0000, 16'h0000, 16'h0020, 8'd7},  // R7 three-of-four
        '{1'b1, 3'd5, 16'hFFFF, 16'hFFFF, 16'h0020, 8'd9},  // R9 code 5
        '{1'b1, 3'd7, 16'hFFFF, 16'h0000, 16'h0020, 8'd9},  // R9 code 7
        '{1'b1, 3'd1, 16'hFFFF, 16'h0000, 16'hFFFF, 8'd4},  // R4 full load
        '{1'b1, 3'd4, 16'h0000, 16'h0000, 16'h6FF6, 8'd8},  // R8 corners clear
        '{1'b1, 3'd1, 16'hFFFF, 16'h0000, 16'hFFFF, 8'd4},  // R4
        '{1'b1, 3'd3, 16'h0000, 16'h0000, 16'h0660, 8'd8},  // R8 border erodes
        '{1'b1, 3'd1, 16'h0001, 16'h0000, 16'h0001, 8'd10}, // R10 corner r0c0
        '{1'b1, 3'd2, 16'h0000, 16'h0000, 16'h0012, 8'd10}, // R10 right+down
        '{1'b1, 3'd1, 16'h0008, 16'h0000, 16'h0008, 8'd10}, // R10 corner r0c3
        '{1'b1, 3'd2, 16'h0000, 16'h0000, 16'h0084, 8'd10}, // R10 left+down
        '{1'b1, 3'd6, 16'hFFFF, 16'hFFFF, 16'h0084, 8'd9}   // R9 code 6
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          step = 1'b0;
    logic [2:0]    op = 3'd0;
    logic [NC-1:0] bright = '0;
    logic [NC-1:0] dark = '0;
    logic [NC-1:0] cells;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    blob_shrink_array #(.N(N)) u0 (
        .clk    (clk),
        .rst    (rst),
        .step   (step),
        .op     (op),
        .bright (bright),
        .dark   (dark),
        .cells  (cells)
    );

    task automatic check(input int req, input logic [NC-1:0] exp);
        checks++;
        if (cells !== exp) begin
            errors++;
            $display("FAIL R%0d: cells=%h expected=%h", req, cells, exp);
        end
    endtask

    // Drive at a falling edge, let one rising edge capture, sample at the next fall.
    task automatic apply(input logic s, input logic [2:0] o,
                         input logic [NC-1:0] b, input logic [NC-1:0] d);
        step = s; op = o; bright = b; dark = d;
        @(negedge clk);
    endtask

    initial begin
        @(negedge clk);
        @(negedge clk);
        check(1, '0);                          // R1 reset state
        rst = 1'b0;

        for (int k = 0; k < NV; k++) begin
            apply(VECS[k].stp, VECS[k].op, VECS[k].br, VECS[k].dk);
            check(int'(VECS[k].req), VECS[k].ex);
        end

        // R1 reset wins over a load strobe
        apply(1'b1, 3'd1, 16'hFFFF, 16'h0000);
        check(4, 16'hFFFF);
        rst = 1'b1;
        apply(1'b1, 3'd1, 16'hFFFF, 16'hFFFF);
        check(1, 16'h0000);
        rst = 1'b0;

        // R2 step low with grow requested keeps a pattern
        apply(1'b1, 3'd0, 16'h0100, 16'h0000);
        check(3, 16'h0100);
        apply(1'b0, 3'd2, 16'h0000, 16'h0000);
        check(2, 16'h0100);

        // R5 grow excludes the cell's own value: lone pixel r2c0 becomes a cross without centre
        apply(1'b1, 3'd2, 16'h0000, 16'h0000);
        check(5, 16'h1210);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule